// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. The converter starts a conversion when its select line falls, holds its data line low while it converts, and raises the line once the result is ready. After that, an external clock shifts the result out, most significant bit first. The controller owns the select line and the serial clock and watches the returning data line. A single start request from the host then runs a whole transaction and returns a 12-bit result together with a one-cycle strobe.

The controller does not wait a fixed conversion time. It begins clocking only when the data line goes high, and it checks that the first bit it samples is a 1. It offers two frame lengths. The short frame uses 13 clocks: the marker bit and then 12 data bits. The long frame uses 16 clocks, sent as two 8-bit reads, and the controller strips the three trailing pad bits. The controller also enforces three wait intervals: a holdoff after reset, a minimum deselect time between transactions, and a longer reacquisition time after a conversion it abandoned on timeout. All timing values are parameters counted in system-clock cycles. The power-up holdoff has two values, and a parameter chooses one according to whether the converter runs from its internal reference or an external one.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset the controller holds csN high and sclk low, and it keeps busy high for the power-up holdoff in system-clock cycles. A startReq seen during that holdoff starts nothing and is not remembered.
- R2: A startReq seen while idle drives csN low on the next clock edge. sclk stays low while the converter is converting.
- R3: Clocking starts only after the synchronised data line is seen high. If the line stays low for EOC_TIMEOUT_CYC cycles, the controller raises csN and pulses timeoutErr for one cycle with no sclk edge and no result. It then keeps csN high for at least ACQ_CYC cycles.
- R4: sclk toggles only while csN is low. Every sclk high phase lasts exactly HALF_CYC cycles. So does every low phase between two rising edges of one frame. The controller samples data on sclk rising edges.
- R5: With byteMode at 0 when the start is accepted, a frame has exactly 13 sclk rising edges. result[11:0] holds samples 2 to 13, first received in bit 11.
- R6: With byteMode at 1 when the start is accepted, a frame has exactly 16 rising edges. result holds samples 2 to 13, and samples 14 to 16 are discarded. byteMode is latched at the start, so changing it during a frame has no effect.
- R7: If the first sample of a frame (the marker bit) is 0, frameErr is 1 in the same cycle as resultValid. Otherwise frameErr is 0.
- R8: csN rises only after the last sclk falling edge of a frame. After a completed frame it stays high for at least CS_HIGH_CYC cycles before the next fall.
- R9: resultValid is a one-cycle pulse that appears in the same cycle as the csN rise that ends a frame.
- R10: A startReq seen while busy is ignored. It produces no further transaction.
- R11: busy is low only when the controller is idle. While busy is low, csN is high and sclk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| startReq | input | 1 | Request one conversion and read |
| byteMode | input | 1 | 1 selects the 16-clock two-byte frame, 0 the 13-clock frame |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles low |
| result | output | 12 | Last conversion result |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| frameErr | output | 1 | Marker bit was 0; qualifies resultValid |
| timeoutErr | output | 1 | One-cycle pulse when the end of conversion never arrived |
| busy | output | 1 | Transaction, holdoff or recovery in progress |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. sclk toggles only under an active select, and each high phase has its exact length. The result strobe is a single cycle and lines up with the select release. A frame error never appears without a result. A timeout releases the select without producing a result. The deselect gap before each new select is long enough, and the required length depends on whether the last transaction completed or timed out. The idle outputs stay quiet. Other behaviour shows only in the bench's scenarios, because each case needs a converter model that answers in a particular way. These cases are: the bit order and pad stripping of the two frame lengths, a marker bit that glitches low, a converter that never finishes, starts that arrive during the holdoff or mid-frame, and a mode input that changes after the start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef struct packed {
    logic clear;
    logic shift;
    logic publish;
    logic wide;
  } rdStrobe_t;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_RECOVER,
    ST_ACQ
  } rdState_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC     = 24,
  parameter int POWERUP_CYC  = 1000,
  parameter int CS_HIGH_CYC  = 24,
  parameter int ACQ_CYC      = 150,
  parameter int TIMEOUT_CYC  = 1000,
  parameter int SETTLE_CYC   = 3,
  parameter int FRAME_NARROW = 13,
  parameter int FRAME_WIDE   = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      byteMode,
  input  logic      sdiSync,
  output logic      csN,
  output logic      sclk,
  output logic      busy,
  output logic      timeoutErr,
  output rdStrobe_t strobe
);

  localparam int MAX_WAIT = maxInt(maxInt(maxInt(POWERUP_CYC, TIMEOUT_CYC),
                                          maxInt(ACQ_CYC, CS_HIGH_CYC)),
                                   maxInt(HALF_CYC, SETTLE_CYC));
  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam int BIT_W = $clog2(FRAME_WIDE + 1);
  localparam logic [CNT_W-1:0] PUP_LAST  = CNT_W'(POWERUP_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] CSH_LAST  = CNT_W'(CS_HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] TOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_N  = CNT_W'(SETTLE_CYC);
  localparam logic [BIT_W-1:0] NARROW_N  = BIT_W'(FRAME_NARROW);
  localparam logic [BIT_W-1:0] WIDE_N    = BIT_W'(FRAME_WIDE);

  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic             wideQ;

  logic phaseEnd;
  logic lastBit;
  logic eocSeen;
  logic timeoutHit;

  assign phaseEnd   = (state == ST_SHIFT) && (cnt == HALF_LAST);
  assign lastBit    = bitCnt == (wideQ ? WIDE_N : NARROW_N);
  assign eocSeen    = (state == ST_CONV) && (cnt >= SETTLE_N) && sdiSync;
  assign timeoutHit = (state == ST_CONV) && !eocSeen && (cnt == TOUT_LAST);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.wide    = wideQ;
    strobe.clear   = (state == ST_IDLE) && startReq;
    strobe.shift   = phaseEnd && !sclk && !lastBit;
    strobe.publish = phaseEnd && !sclk && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_POWERUP;
      cnt        <= '0;
      bitCnt     <= '0;
      wideQ      <= 1'b0;
      csN        <= 1'b1;
      sclk       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      timeoutErr <= 1'b0;
      unique case (state)
        ST_POWERUP: begin
          if (cnt == PUP_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (startReq) begin
            csN   <= 1'b0;
            wideQ <= byteMode;
            cnt   <= '0;
            state <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (eocSeen) begin
            state  <= ST_SHIFT;
            cnt    <= '0;
            bitCnt <= '0;
          end else if (timeoutHit) begin
            csN        <= 1'b1;
            timeoutErr <= 1'b1;
            cnt        <= '0;
            state      <= ST_ACQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            cnt <= '0;
            if (sclk) begin
              sclk <= 1'b0;
            end else if (lastBit) begin
              csN   <= 1'b1;
              state <= ST_RECOVER;
            end else begin
              sclk   <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cnt == CSH_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACQ: begin
          if (cnt == ACQ_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int FRAME_WIDE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdiIn,
  input  rdStrobe_t        strobe,
  output logic             sdiSync,
  output logic [RES_W-1:0] result,
  output logic             resultValid,
  output logic             frameErr
);

  logic [FRAME_WIDE-1:0] shreg;
  logic [RES_W-1:0]      pickData;
  logic                  pickLead;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= sdiIn;
      end
      assign sdiSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdiIn};
      end
      assign sdiSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    if (strobe.wide) begin
      pickData = shreg[FRAME_WIDE-2 -: RES_W];
      pickLead = shreg[FRAME_WIDE-1];
    end else begin
      pickData = shreg[RES_W-1:0];
      pickLead = shreg[RES_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg       <= '0;
      result      <= '0;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
      if (strobe.clear) begin
        shreg <= '0;
      end else if (strobe.shift) begin
        shreg <= {shreg[FRAME_WIDE-2:0], sdiSync};
      end
      if (strobe.publish) begin
        result      <= pickData;
        resultValid <= 1'b1;
        frameErr    <= !pickLead;
      end
    end
  end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int RES_W           = 12,
  parameter int HALF_CYC        = 24,
  parameter bit USE_INT_REF     = 1'b1,
  parameter int POWERUP_INT_CYC = 2_000_000,
  parameter int POWERUP_EXT_CYC = 1_000,
  parameter int CS_HIGH_CYC     = 24,
  parameter int ACQ_CYC         = 150,
  parameter int EOC_TIMEOUT_CYC = 1_000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             byteMode,
  input  logic             sdi,
  output logic             csN,
  output logic             sclk,
  output logic [RES_W-1:0] result,
  output logic             resultValid,
  output logic             frameErr,
  output logic             timeoutErr,
  output logic             busy
);

  localparam int FRAME_NARROW = RES_W + 1;
  localparam int FRAME_WIDE   = ((RES_W + 1 + 7) / 8) * 8;
  localparam int POWERUP_CYC  = USE_INT_REF ? POWERUP_INT_CYC : POWERUP_EXT_CYC;
  localparam int SETTLE_CYC   = SYNC_STAGES + 1;

  rdStrobe_t strobe;
  logic      sdiSync;

  adc_rd_ctrl #(
    .HALF_CYC    (HALF_CYC),
    .POWERUP_CYC (POWERUP_CYC),
    .CS_HIGH_CYC (CS_HIGH_CYC),
    .ACQ_CYC     (ACQ_CYC),
    .TIMEOUT_CYC (EOC_TIMEOUT_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .FRAME_NARROW(FRAME_NARROW),
    .FRAME_WIDE  (FRAME_WIDE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .byteMode  (byteMode),
    .sdiSync   (sdiSync),
    .csN       (csN),
    .sclk      (sclk),
    .busy      (busy),
    .timeoutErr(timeoutErr),
    .strobe    (strobe)
  );

  adc_rd_datapath #(
    .RES_W      (RES_W),
    .FRAME_WIDE (FRAME_WIDE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdiIn      (sdi),
    .strobe     (strobe),
    .sdiSync    (sdiSync),
    .result     (result),
    .resultValid(resultValid),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int HALF_CYC    = 24,
  parameter int CS_HIGH_CYC = 24,
  parameter int ACQ_CYC     = 150
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic resultValid,
  input logic frameErr,
  input logic timeoutErr,
  input logic busy
);

  localparam int CAP = (ACQ_CYC > CS_HIGH_CYC) ? ACQ_CYC : CS_HIGH_CYC;

  int   hiCnt;
  int   csHiCnt;
  logic lastAbort;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt     <= 0;
      csHiCnt   <= 0;
      lastAbort <= 1'b0;
    end else begin
      hiCnt <= sclk ? hiCnt + 1 : 0;
      if (!csN)              csHiCnt <= 0;
      else if (csHiCnt < CAP) csHiCnt <= csHiCnt + 1;
      if (timeoutErr)       lastAbort <= 1'b1;
      else if (resultValid) lastAbort <= 1'b0;
    end
  end

  assert_sclk_needs_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  assert_high_phase_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> hiCnt == HALF_CYC);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_valid_at_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(csN));

  assert_ferr_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> resultValid);

  assert_timeout_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> ($rose(csN) && !resultValid && !sclk));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sclk));

  assert_deselect_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> csHiCnt >= (lastAbort ? ACQ_CYC : CS_HIGH_CYC));

endmodule

bind adc_serial_reader adc_serial_reader_chk #(
  .HALF_CYC   (HALF_CYC),
  .CS_HIGH_CYC(CS_HIGH_CYC),
  .ACQ_CYC    (ACQ_CYC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .sclk       (sclk),
  .resultValid(resultValid),
  .frameErr   (frameErr),
  .timeoutErr (timeoutErr),
  .busy       (busy)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;

  localparam int HALF = 4;
  localparam int CSH  = 6;
  localparam int ACQ  = 20;
  localparam int TOUT = 60;
  localparam int PUP  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic byteMode = 1'b0;
  logic sdi = 1'b0;
  logic csN, sclk, resultValid, frameErr, timeoutErr, busy;
  logic [11:0] result;

  always #5 clk = ~clk;

  adc_serial_reader #(
    .RES_W(12), .HALF_CYC(HALF), .USE_INT_REF(1'b0), .POWERUP_INT_CYC(5000),
    .POWERUP_EXT_CYC(PUP), .CS_HIGH_CYC(CSH), .ACQ_CYC(ACQ),
    .EOC_TIMEOUT_CYC(TOUT), .SYNC_STAGES(2)
  ) u_adc_serial_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteMode(byteMode), .sdi(sdi),
    .csN(csN), .sclk(sclk), .result(result), .resultValid(resultValid),
    .frameErr(frameErr), .timeoutErr(timeoutErr), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: 0 normal, 1 marker glitches low, 2 never finishes
  logic [11:0] mData = '0;
  int mMode = 0;
  int mDelay = 20;

  initial begin
    logic pCs = 1'b1;
    logic pSclk = 1'b0;
    int convCnt = -1;
    int idx = 0;
    forever begin
      @(negedge clk);
      if (csN) begin
        sdi <= 1'b0;
        convCnt = -1;
      end else begin
        if (pCs) begin
          convCnt = 0;
          idx = 0;
          sdi <= 1'b0;
        end else if (convCnt >= 0) begin
          convCnt++;
          if (convCnt == mDelay && mMode != 2) sdi <= 1'b1;
          if (convCnt == mDelay + 1 && mMode == 1) sdi <= 1'b0;
        end
        if (pSclk && !sclk) begin
          idx++;
          convCnt = -1;
          sdi <= (idx >= 1 && idx <= 12) ? mData[12-idx] : 1'b0;
        end
      end
      pCs = csN;
      pSclk = sclk;
    end
  end

  typedef struct {
    logic [11:0] data;
    bit ferr;
    bit tout;
    int clocks;
    string tag;
  } exp_t;
  exp_t expQ[$];

  // monitor
  initial begin
    logic pCs = 1'b1;
    logic pSclk = 1'b0;
    int riseCnt = 0, hiLen = 0, loLen = 0, gapLen = 0;
    bit released = 0, lastTout = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        pCs = 1'b1; pSclk = 1'b0; riseCnt = 0; released = 0;
        continue;
      end
      if (sclk && !pSclk) begin
        if (riseCnt > 0) check(loLen == HALF, "R4 low phase", loLen, HALF);
        riseCnt++;
        hiLen = 0;
      end
      if (!sclk && pSclk) begin
        check(hiLen == HALF, "R4 high phase", hiLen, HALF);
        loLen = 0;
      end
      if (sclk) hiLen++; else loLen++;
      if (csN && !pCs) gapLen = 0;
      if (!csN && pCs) begin
        if (released) begin
          if (lastTout) check(gapLen >= ACQ, "R3 reacquire gap", gapLen, ACQ);
          else          check(gapLen >= CSH, "R8 deselect gap", gapLen, CSH);
        end
        riseCnt = 0;
      end
      if (csN) gapLen++;
      if (resultValid || timeoutErr) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected transaction", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(timeoutErr == e.tout, {e.tag, " timeout flag"}, timeoutErr, e.tout);
          check(riseCnt == e.clocks, {e.tag, " clock count"}, riseCnt, e.clocks);
          if (!e.tout) begin
            check(result == e.data, {e.tag, " result"}, result, e.data);
            check(frameErr == e.ferr, {e.tag, " R7 frameErr"}, frameErr, e.ferr);
          end
        end
        released = 1;
        lastTout = timeoutErr;
      end
      pCs = csN;
      pSclk = sclk;
    end
  end

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic runConv(input logic [11:0] d, input bit wide, input int delay,
                         input int mode, input string tag);
    exp_t e;
    waitIdle();
    mData = d; mMode = mode; mDelay = delay;
    e.data = d; e.ferr = (mode == 1); e.tout = (mode == 2);
    e.clocks = (mode == 2) ? 0 : (wide ? 16 : 13);
    e.tag = tag;
    expQ.push_back(e);
    startReq = 1'b1;
    byteMode = wide;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(csN == 1'b1, "R1 reset csN", csN, 1);
    check(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    check(busy == 1'b1, "R1 reset busy", busy, 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (PUP - 10) @(negedge clk);
    check(busy == 1'b1, "R1 holdoff busy", busy, 1);
    check(csN == 1'b1, "R1 start ignored in holdoff", csN, 1);
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R1 holdoff over", busy, 0);
    check(csN == 1'b1, "R10 holdoff start not remembered", csN, 1);

    // R2: select falls next edge and clock is quiet while converting
    mData = 12'hABC; mMode = 0; mDelay = 30;
    begin
      exp_t e;
      e.data = 12'hABC; e.ferr = 0; e.tout = 0; e.clocks = 13; e.tag = "R5 narrow";
      expQ.push_back(e);
    end
    startReq = 1'b1;
    byteMode = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    check(csN == 1'b0, "R2 csN low after start", csN, 0);
    repeat (15) @(negedge clk);
    check(sclk == 1'b0, "R2 sclk low during conversion", sclk, 0);
    check(busy == 1'b1, "R11 busy during conversion", busy, 1);
    waitIdle();

    runConv(12'h5A3, 1'b1, 12, 0, "R6 wide");
    runConv(12'hFFF, 1'b0, 40, 0, "R5 narrow all ones");
    runConv(12'h000, 1'b1, 15, 0, "R6 wide all zeros");
    runConv(12'h801, 1'b0, 20, 1, "R7 narrow glitch");
    runConv(12'h7FE, 1'b1, 20, 1, "R7 wide glitch");
    runConv(12'h123, 1'b0, 20, 2, "R3 timeout");
    check(csN == 1'b1 && busy == 1'b0, "R11 idle after timeout", csN, 1);
    runConv(12'h9C6, 1'b0, 25, 0, "R3 after reacquire");

    // R6: mode changed after start has no effect
    waitIdle();
    mData = 12'h3D5; mMode = 0; mDelay = 20;
    begin
      exp_t e;
      e.data = 12'h3D5; e.ferr = 0; e.tout = 0; e.clocks = 16; e.tag = "R6 latched mode";
      expQ.push_back(e);
    end
    startReq = 1'b1;
    byteMode = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    byteMode = 1'b0;
    // R10: start pulsed mid-frame
    repeat (40) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    repeat (40) @(negedge clk);
    check(csN == 1'b1, "R10 mid-frame start ignored", csN, 1);
    check(expQ.size() == 0, "R10 queue drained", expQ.size(), 0);

    // R8: back-to-back with start held
    mData = 12'hC3A; mMode = 0; mDelay = 14;
    begin
      exp_t e;
      e.data = 12'hC3A; e.ferr = 0; e.tout = 0; e.clocks = 13; e.tag = "R8 back-to-back";
      expQ.push_back(e);
      expQ.push_back(e);
    end
    startReq = 1'b1;
    byteMode = 1'b0;
    @(negedge csN);
    @(posedge csN);
    @(negedge csN);
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R9 all results seen", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule